// File: doc/BRIEF.md
# Averaging and Channel-Swap Sequencer

This block steps a measurement front end through repeated acquisition cycles so that a downstream averager sees a programmed number of results, and it decides which of two transmit/receive channel pairs is active for each cycle. Each completed acquisition is reported to it by a one-clock `cycle_done` strobe. The block counts these completions toward a power-of-two target. When the target is reached it raises `avg_done` for one clock and starts counting again from zero. The time values themselves are accumulated elsewhere.

The channel comes from one of three sources. An external pin, when enabled, has the highest priority. Next is automatic alternation, which applies only in measurement mode 2 with swap enabled. Otherwise the channel is a fixed register selection. With alternation active, one averaging step is a pair of acquisitions, one on each channel. An `abort` request, raised when an error is cleared, discards all progress.

The sequencer is a three-state machine:
- `ST_IDLE`: no steps counted, first half of any pair.
- `ST_ACCUM`: some steps counted, first half of any pair.
- `ST_PAIR`: first acquisition of a swap pair done, waiting for the second.

It has five transitions:
- `T_START_PAIR`: IDLE/ACCUM to PAIR, on a completion while swap is active.
- `T_STEP`: to ACCUM with the count plus one, on a counted completion below target.
- `T_WRAP`: to IDLE with the count at zero and done pulsed, on a counted completion that reaches target.
- `T_PAIR_DROP`: PAIR to IDLE or ACCUM, when swap turns inactive with no completion.
- `T_ABORT`: any state to IDLE, with the count cleared.

Top module: `sq_sequencer`

## Requirements
- R1: The target step count is 2 to the power `avg_code` (code 0 gives 1 step, code 7 gives 128 steps). After reset or a wrap, the `target`-th counted step wraps.
- R2: On a wrapping step, `avg_done` is 1 for exactly the one clock after that edge, and `cycle_count` reads 0 in that clock. `avg_done` is 0 at all other times.
- R3: `cycle_count` rises by one on each non-wrapping counted step and holds its value when there is no `cycle_done` and no `abort`.
- R4: When neither the pin override nor swap is active, `active_chan` equals `reg_chan` (0 = channel 1, 1 = channel 2). After reset, the pair phase is the first half.
- R5: Swap is active when `meas_mode` = 2, `swap_en` = 1 and `ext_chan_en` = 0. `active_chan` is then `reg_chan` in the first half of a pair and the opposite channel in the second half. The half flips on every `cycle_done`.
- R6: With swap active, only the second completion of a pair is a counted step. The first completion leaves `cycle_count` unchanged.
- R7: When `ext_chan_en` = 1, `active_chan` equals `ext_chan_pin` in the same cycle, regardless of `swap_en`, `meas_mode` and `reg_chan`.
- R8: `abort` clears `cycle_count` and the pair phase and suppresses `avg_done`, even when it arrives together with `cycle_done`.
- R9: `meas_mode` codes 0, 1 and 3 never activate swap. Code 3 is handled as mode 0.
- R10: If swap becomes inactive while in the second half of a pair with no completion, the half is discarded and `cycle_count` is kept.
- R11: If `avg_code` is lowered so that the count plus one is at or above the new target, the next counted step wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_done | input | 1 | One-clock strobe: an acquisition cycle finished |
| avg_code | input | 3 | Averaging code, target = 2**avg_code |
| meas_mode | input | 2 | Measurement mode, 2 enables swap, 3 treated as 0 |
| swap_en | input | 1 | Automatic channel alternation enable |
| reg_chan | input | 1 | Register channel select, 0 = channel 1, 1 = channel 2 |
| ext_chan_en | input | 1 | Pin override enable |
| ext_chan_pin | input | 1 | External channel-select pin |
| abort | input | 1 | Clears averaging progress and swap phase |
| active_chan | output | 1 | Active channel pair, 0 = channel 1, 1 = channel 2 |
| avg_done | output | 1 | One-clock strobe: programmed number of steps reached |
| cycle_count | output | 8 | Counted steps in the current average |

## Verification
The assertions hold on every cycle for:
- pin priority over channel selection;
- the fixed register channel when neither override nor swap applies;
- clearing on abort;
- holding the count when no completion arrives;
- the count being zero whenever done is raised;
- the channel flipping after a completion while swap stays steady.

Several behaviours need the bench's scenarios and its reference model:
- that the wrap lands on exactly the 2**code-th step;
- that only the second half of a pair counts;
- that mode 3 acts like mode 0;
- that a dropped half-pair keeps its count;
- that lowering the code mid-average wraps early.

// File: rtl/sq_pkg.sv
package sq_pkg;
    parameter int AVG_CODE_W = 3;
    parameter int MODE_W     = 2;
    localparam int CNT_W     = 2 ** AVG_CODE_W;
    localparam logic [MODE_W-1:0] MODE_ALTERNATE = MODE_W'(2);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_PAIR  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/sq_avg_target.sv
module sq_avg_target
    import sq_pkg::*;
(
    input  logic [AVG_CODE_W-1:0] code,
    output logic [CNT_W:0]        target
);
    // target = 2**code, built as a one-hot decode
    always_comb begin
        target = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (code == AVG_CODE_W'(i)) begin
                target[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sq_swap_qualify.sv
module sq_swap_qualify
    import sq_pkg::*;
(
    input  logic [MODE_W-1:0] meas_mode,
    input  logic              swap_en,
    input  logic              ext_chan_en,
    output logic              swap_act
);
    logic mode_alt;

    always_comb begin
        unique case (meas_mode)
            MODE_ALTERNATE: mode_alt = 1'b1;
            default:        mode_alt = 1'b0; // modes 0, 1 and reserved 3
        endcase
        swap_act = mode_alt && swap_en && !ext_chan_en;
    end
endmodule

// File: rtl/sq_chan_select.sv
module sq_chan_select (
    input  logic ext_chan_en,
    input  logic ext_chan_pin,
    input  logic swap_act,
    input  logic reg_chan,
    input  logic second_half,
    output logic active_chan
);
    always_comb begin
        if (ext_chan_en) begin
            active_chan = ext_chan_pin;
        end else if (swap_act) begin
            active_chan = reg_chan ^ second_half;
        end else begin
            active_chan = reg_chan;
        end
    end
endmodule

// File: rtl/sq_seq_fsm.sv
module sq_seq_fsm
    import sq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_done,
    input  logic             swap_act,
    input  logic             abort,
    input  logic [CNT_W:0]   target,
    output logic             second_half,
    output logic             avg_done,
    output logic [CNT_W-1:0] cycle_count
);
    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_q, done_d;
    logic             step;
    logic [CNT_W:0]   cnt_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        step    = 1'b0;
        cnt_inc = {1'b0, cnt_q} + 1'b1;

        unique case (state_q)
            ST_IDLE, ST_ACCUM: begin
                if (cycle_done) begin
                    if (swap_act) begin
                        state_d = ST_PAIR;          // T_START_PAIR
                    end else begin
                        step = 1'b1;
                    end
                end
            end
            ST_PAIR: begin
                if (cycle_done) begin
                    step = 1'b1;
                end else if (!swap_act) begin       // T_PAIR_DROP
                    state_d = (cnt_q == '0) ? ST_IDLE : ST_ACCUM;
                end
            end
            default: state_d = ST_IDLE;
        endcase

        if (step) begin
            if (cnt_inc >= target) begin            // T_WRAP
                state_d = ST_IDLE;
                cnt_d   = '0;
                done_d  = 1'b1;
            end else begin                          // T_STEP
                state_d = ST_ACCUM;
                cnt_d   = cnt_inc[CNT_W-1:0];
            end
        end

        if (abort) begin                            // T_ABORT
            state_d = ST_IDLE;
            cnt_d   = '0;
            done_d  = 1'b0;
        end
    end

    always_comb begin
        second_half = (state_q == ST_PAIR);
        avg_done    = done_q;
        cycle_count = cnt_q;
    end
endmodule

// File: rtl/sq_sequencer.sv
module sq_sequencer
    import sq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cycle_done,
    input  logic [AVG_CODE_W-1:0] avg_code,
    input  logic [MODE_W-1:0]     meas_mode,
    input  logic                  swap_en,
    input  logic                  reg_chan,
    input  logic                  ext_chan_en,
    input  logic                  ext_chan_pin,
    input  logic                  abort,
    output logic                  active_chan,
    output logic                  avg_done,
    output logic [CNT_W-1:0]      cycle_count
);
    logic [CNT_W:0] target;
    logic           swap_act;
    logic           second_half;

    sq_avg_target u_target (
        .code   (avg_code),
        .target (target)
    );

    sq_swap_qualify u_qual (
        .meas_mode   (meas_mode),
        .swap_en     (swap_en),
        .ext_chan_en (ext_chan_en),
        .swap_act    (swap_act)
    );

    sq_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_done  (cycle_done),
        .swap_act    (swap_act),
        .abort       (abort),
        .target      (target),
        .second_half (second_half),
        .avg_done    (avg_done),
        .cycle_count (cycle_count)
    );

    sq_chan_select u_chan (
        .ext_chan_en  (ext_chan_en),
        .ext_chan_pin (ext_chan_pin),
        .swap_act     (swap_act),
        .reg_chan     (reg_chan),
        .second_half  (second_half),
        .active_chan  (active_chan)
    );
endmodule

// File: rtl/sq_sequencer_chk.sv
module sq_sequencer_chk
    import sq_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cycle_done,
    input logic [AVG_CODE_W-1:0] avg_code,
    input logic [MODE_W-1:0]     meas_mode,
    input logic                  swap_en,
    input logic                  reg_chan,
    input logic                  ext_chan_en,
    input logic                  ext_chan_pin,
    input logic                  abort,
    input logic                  active_chan,
    input logic                  avg_done,
    input logic [CNT_W-1:0]      cycle_count
);
    logic alt_on;
    assign alt_on = (meas_mode == 2'd2) && swap_en && !ext_chan_en;

    a_r7_pin_override: assert property (@(posedge clk) disable iff (!rst_n)
        ext_chan_en |-> (active_chan == ext_chan_pin));

    a_r4_fixed_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_chan_en && !alt_on) |-> (active_chan == reg_chan));

    a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (cycle_count == '0 && !avg_done));

    a_r3_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cycle_done && !abort) |=> ($stable(cycle_count) && !avg_done));

    a_r2_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        avg_done |-> (cycle_count == '0));

    a_r5_swap_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_on && cycle_done && !abort) |=>
            (!alt_on || !$stable(reg_chan) || (active_chan != $past(active_chan))));
endmodule

bind sq_sequencer sq_sequencer_chk u_chk (.*);

// File: tb/tb_sq_sequencer.sv
module tb_sq_sequencer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cycle_done = 1'b0;
    logic [2:0] avg_code = 3'd0;
    logic [1:0] meas_mode = 2'd0;
    logic       swap_en = 1'b0;
    logic       reg_chan = 1'b0;
    logic       ext_chan_en = 1'b0;
    logic       ext_chan_pin = 1'b0;
    logic       abort = 1'b0;
    logic       active_chan;
    logic       avg_done;
    logic [7:0] cycle_count;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    // reference model state
    int  m_cnt = 0;
    bit  m_half = 1'b0;
    bit  m_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sq_sequencer dut (.*);

    function automatic bit swap_on(input logic [1:0] md, input logic se, input logic xe);
        return (md == 2'd2) && se && !xe;
    endfunction

    function automatic bit exp_chan();
        if (ext_chan_en) return ext_chan_pin;
        if (swap_on(meas_mode, swap_en, ext_chan_en)) return reg_chan ^ m_half;
        return reg_chan;
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit sw = swap_on(meas_mode, swap_en, ext_chan_en);
        if (abort) begin
            m_cnt = 0; m_half = 0; m_done = 0;
        end else if (cycle_done) begin
            if (sw && !m_half) begin
                m_half = 1; m_done = 0;
            end else begin
                m_half = 0;
                if (m_cnt + 1 >= (1 << avg_code)) begin
                    m_cnt = 0; m_done = 1;
                end else begin
                    m_cnt++; m_done = 0;
                end
            end
        end else begin
            m_done = 0;
            if (!sw) m_half = 0;
        end
    endtask

    // called at a negedge with inputs already set; returns at the next negedge
    task automatic step(input string tag);
        string ctag;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (ext_chan_en) ctag = "R7 channel";
        else if (swap_on(meas_mode, swap_en, ext_chan_en)) ctag = "R5 channel";
        else ctag = "R4 channel";
        check(int'(active_chan), int'(exp_chan()), ctag);
        check(int'(avg_done), int'(m_done), {tag, " done"});
        check(int'(cycle_count), m_cnt, {tag, " count"});
    endtask

    task automatic pulse(input string tag);
        cycle_done = 1'b1;
        step(tag);
        cycle_done = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(int'(cycle_count), 0, "R3 reset count");
        check(int'(avg_done), 0, "R2 reset done");
        check(int'(active_chan), 0, "R4 reset channel");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: code 3 -> wrap on the 8th step
        avg_code = 3'd3;
        for (int i = 0; i < 7; i++) pulse("R1 step");
        check(int'(cycle_count), 7, "R1 count before wrap");
        pulse("R1 wrap");
        check(int'(avg_done), 1, "R2 done on wrap");
        step("R2 idle after wrap");
        check(int'(avg_done), 0, "R2 single pulse");

        // R1 boundary: code 0 -> every completion wraps
        avg_code = 3'd0;
        pulse("R1 code0");
        check(int'(avg_done), 1, "R1 code0 wraps");

        // R1 boundary: code 7 -> 128 steps
        avg_code = 3'd7;
        for (int i = 0; i < 127; i++) pulse("R1 long");
        check(int'(cycle_count), 127, "R1 code7 count");
        pulse("R1 long wrap");
        check(int'(avg_done), 1, "R1 code7 wraps");

        // R6 / R5: swap pairs, code 1 -> 2 steps = 4 completions
        avg_code = 3'd1; meas_mode = 2'd2; swap_en = 1'b1; reg_chan = 1'b1;
        step("R5 setup");
        check(int'(active_chan), 1, "R5 first half uses reg");
        pulse("R6 first half");
        check(int'(cycle_count), 0, "R6 first half not counted");
        check(int'(active_chan), 0, "R5 second half flips");
        pulse("R6 second half");
        check(int'(cycle_count), 1, "R6 pair counted");
        pulse("R6 half"); pulse("R6 wrap");
        check(int'(avg_done), 1, "R6 wrap after two pairs");

        // R7: override beats swap
        ext_chan_en = 1'b1; ext_chan_pin = 1'b0;
        step("R7 hold");
        check(int'(active_chan), 0, "R7 pin low");
        ext_chan_pin = 1'b1; reg_chan = 1'b0;
        step("R7 hold");
        check(int'(active_chan), 1, "R7 pin high");
        ext_chan_en = 1'b0;

        // R10: drop swap mid-pair
        avg_code = 3'd2; reg_chan = 1'b0;
        pulse("R10 pair a"); pulse("R10 pair b"); pulse("R10 half");
        check(int'(active_chan), 1, "R10 in second half");
        swap_en = 1'b0;
        step("R10 drop");
        check(int'(cycle_count), 1, "R10 count kept");
        swap_en = 1'b1;
        step("R10 resume");
        check(int'(active_chan), 0, "R10 half discarded");

        // R9: mode 3 and mode 1 never swap
        meas_mode = 2'd3;
        pulse("R9 mode3");
        check(int'(active_chan), 0, "R9 mode3 no swap");
        meas_mode = 2'd1;
        pulse("R9 mode1");
        check(int'(active_chan), 0, "R9 mode1 no swap");

        // R8: abort with simultaneous completion
        meas_mode = 2'd0; avg_code = 3'd3;
        pulse("R8 pre");
        abort = 1'b1; cycle_done = 1'b1;
        step("R8 abort");
        abort = 1'b0; cycle_done = 1'b0;
        check(int'(cycle_count), 0, "R8 cleared");
        check(int'(avg_done), 0, "R8 no done");

        // R11: lower code mid-average
        avg_code = 3'd4;
        for (int i = 0; i < 5; i++) pulse("R11 fill");
        avg_code = 3'd1;
        pulse("R11 early wrap");
        check(int'(avg_done), 1, "R11 wraps after lowering");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            cycle_done   = ($urandom % 3) == 0;
            abort        = ($urandom % 40) == 0;
            if (($urandom % 50) == 0) avg_code = 3'($urandom % 5);
            if (($urandom % 30) == 0) meas_mode = 2'($urandom);
            if (($urandom % 30) == 0) swap_en = 1'($urandom);
            if (($urandom % 40) == 0) reg_chan = 1'($urandom);
            if (($urandom % 60) == 0) ext_chan_en = 1'($urandom);
            ext_chan_pin = 1'($urandom);
            step("R3 random");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule